// File: doc/BRIEF.md
# Per-Bank DRAM Command Timing Guard

This block sits in front of the command path of a DRAM controller and decides, one request at a time, whether a command may go to the device now. It keeps a row-open flag for each of eight banks. It also keeps three down-counters per bank: activate-to-column, precharge recovery, and activate-to-activate. A request that is legal and whose intervals have run out is granted. A request that is legal but early is stalled, and the requester presents it again later. A request that makes no sense for the bank state is rejected with an error.

The minimum intervals are parameters given in picoseconds, together with the clock period. The block converts each one to whole cycles, rounding up. A static input selects the faster or the slower speed grade. At the default 2.5 ns clock the fast grade needs 5, 5 and 23 cycles, and the slow grade needs 6, 6 and 24 cycles. The verdict for a request presented in cycle t appears on registered outputs in cycle t+1. Any bank state change lands on the same edge.

Top module: `bank_timing_guard`

## Requirements
- R1: Synchronous reset clears all responses and marks every bank closed, whatever state existed before.
- R2: The command codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. A valid request with codes 1 to 5 gets exactly one of grant, stall or error in the next cycle. Codes 0, 6 and 7 get no response.
- R3: An activate to a closed bank whose intervals have expired is granted and opens the bank. An activate to an open bank gets an error.
- R4: A read or write to a closed bank gets an error. A read or write to an open bank is stalled until the row-to-column cycle count has passed since that bank's activate, and is granted from then on.
- R5: After a precharge closes a bank, an activate to that bank is stalled until the precharge cycle count has passed.
- R6: Activates to the same bank are separated by at least the row-cycle count; an earlier one is stalled.
- R7: A precharge is always granted. It closes an open bank and restarts that bank's precharge counter. On a closed bank it has no effect and restarts nothing.
- R8: A refresh is granted only when every bank is closed and every precharge counter has expired; otherwise it is stalled. A granted refresh changes no bank state.
- R9: Banks are independent: one bank's counters and flag never delay or reject a command to another bank.
- R10: bin_sel=0 loads fast-grade counts (5/5/23 cycles by default) and bin_sel=1 loads slow-grade counts (6/6/24).
- R11: A stalled or rejected command leaves every bank flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bin_sel | input | 1 | Speed grade: 0 fast, 1 slow |
| req_valid | input | 1 | A command request is present this cycle |
| req_cmd | input | 3 | Command code (see R2) |
| req_bank | input | 3 | Target bank index |
| rsp_grant | output | 1 | Previous-cycle request was issued |
| rsp_stall | output | 1 | Previous-cycle request was too early |
| rsp_err | output | 1 | Previous-cycle request was illegal for the bank state |
| bank_open | output | 8 | Row-open flag per bank |

## Verification
A counter that reloads with the wrong value, or that does not restart, shows at the ports as a stall that ends one cycle early or late. That is visible in the first cycle a retried command should change from stall to grant, so the bench probes the exact boundary cycle of each interval in both grades. A wrong open flag shows on bank_open in the cycle after the command that corrupted it. It also shows as an error where a grant was due. A counter leaking between banks appears as a stall on an otherwise idle bank.

// File: rtl/bank_timing_pkg.sv
package bank_timing_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    VERD_NONE,
    VERD_GRANT,
    VERD_STALL,
    VERD_ERR
  } verdict_e;

  // round a picosecond minimum up to whole clock cycles
  function automatic int ps_to_cycles(input int ps, input int tck_ps);
    return (ps + tck_ps - 1) / tck_ps;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bank_interval_sel.sv
module bank_interval_sel #(
  parameter int CNT_W    = 5,
  parameter int F_RCD    = 5,
  parameter int F_RP     = 5,
  parameter int F_RC     = 23,
  parameter int S_RCD    = 6,
  parameter int S_RP     = 6,
  parameter int S_RC     = 24
) (
  input  logic             bin_sel,
  output logic [CNT_W-1:0] rcd_rl,
  output logic [CNT_W-1:0] rp_rl,
  output logic [CNT_W-1:0] rc_rl
);

  // reload values are count-1: the counter reaches zero in the first legal cycle
  localparam logic [CNT_W-1:0] F_RCD_RL = CNT_W'(F_RCD - 1);
  localparam logic [CNT_W-1:0] F_RP_RL  = CNT_W'(F_RP - 1);
  localparam logic [CNT_W-1:0] F_RC_RL  = CNT_W'(F_RC - 1);
  localparam logic [CNT_W-1:0] S_RCD_RL = CNT_W'(S_RCD - 1);
  localparam logic [CNT_W-1:0] S_RP_RL  = CNT_W'(S_RP - 1);
  localparam logic [CNT_W-1:0] S_RC_RL  = CNT_W'(S_RC - 1);

  always_comb begin
    if (bin_sel) begin
      rcd_rl = S_RCD_RL;
      rp_rl  = S_RP_RL;
      rc_rl  = S_RC_RL;
    end else begin
      rcd_rl = F_RCD_RL;
      rp_rl  = F_RP_RL;
      rc_rl  = F_RC_RL;
    end
  end

endmodule

// File: rtl/bank_timer.sv
module bank_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             open_go,
  input  logic             close_go,
  input  logic [CNT_W-1:0] rcd_rl,
  input  logic [CNT_W-1:0] rp_rl,
  input  logic [CNT_W-1:0] rc_rl,
  output logic             row_open,
  output logic             col_ok,
  output logic             pre_ok,
  output logic             cyc_ok
);

  logic [CNT_W-1:0] rcd_left;
  logic [CNT_W-1:0] rp_left;
  logic [CNT_W-1:0] rc_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_open <= 1'b0;
      rcd_left <= '0;
      rp_left  <= '0;
      rc_left  <= '0;
    end else begin
      if (open_go)       row_open <= 1'b1;
      else if (close_go) row_open <= 1'b0;

      if (open_go)               rcd_left <= rcd_rl;
      else if (rcd_left != '0)   rcd_left <= rcd_left - 1'b1;

      if (open_go)               rc_left <= rc_rl;
      else if (rc_left != '0)    rc_left <= rc_left - 1'b1;

      if (close_go)              rp_left <= rp_rl;
      else if (rp_left != '0)    rp_left <= rp_left - 1'b1;
    end
  end

  assign col_ok = (rcd_left == '0);
  assign pre_ok = (rp_left == '0);
  assign cyc_ok = (rc_left == '0);

endmodule

// File: rtl/bank_cmd_judge.sv
module bank_cmd_judge
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 3
) (
  input  logic                 req_valid,
  input  logic [2:0]           req_cmd,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [NUM_BANKS-1:0] open_vec,
  input  logic [NUM_BANKS-1:0] col_ok_vec,
  input  logic [NUM_BANKS-1:0] pre_ok_vec,
  input  logic [NUM_BANKS-1:0] cyc_ok_vec,
  output verdict_e             verdict,
  output logic [NUM_BANKS-1:0] open_go,
  output logic [NUM_BANKS-1:0] close_go
);

  logic bank_is_open;
  logic all_quiet;

  assign bank_is_open = open_vec[req_bank];
  assign all_quiet    = (open_vec == '0) && (&pre_ok_vec);

  always_comb begin
    verdict  = VERD_NONE;
    open_go  = '0;
    close_go = '0;
    if (req_valid) begin
      case (cmd_e'(req_cmd))
        CMD_ACT: begin
          if (bank_is_open) begin
            verdict = VERD_ERR;
          end else if (pre_ok_vec[req_bank] && cyc_ok_vec[req_bank]) begin
            verdict           = VERD_GRANT;
            open_go[req_bank] = 1'b1;
          end else begin
            verdict = VERD_STALL;
          end
        end
        CMD_RD, CMD_WR: begin
          if (!bank_is_open)             verdict = VERD_ERR;
          else if (col_ok_vec[req_bank]) verdict = VERD_GRANT;
          else                           verdict = VERD_STALL;
        end
        CMD_PRE: begin
          verdict            = VERD_GRANT;
          close_go[req_bank] = bank_is_open;
        end
        CMD_REF: begin
          verdict = all_quiet ? VERD_GRANT : VERD_STALL;
        end
        default: verdict = VERD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/bank_timing_guard.sv
module bank_timing_guard
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int TCK_PS      = 2500,
  parameter int FAST_RCD_PS = 12500,
  parameter int FAST_RP_PS  = 12500,
  parameter int FAST_RC_PS  = 57500,
  parameter int SLOW_RCD_PS = 15000,
  parameter int SLOW_RP_PS  = 15000,
  parameter int SLOW_RC_PS  = 60000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bin_sel,
  input  logic                 req_valid,
  input  logic [2:0]           req_cmd,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  output logic                 rsp_grant,
  output logic                 rsp_stall,
  output logic                 rsp_err,
  output logic [NUM_BANKS-1:0] bank_open
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int F_RCD  = ps_to_cycles(FAST_RCD_PS, TCK_PS);
  localparam int F_RP   = ps_to_cycles(FAST_RP_PS, TCK_PS);
  localparam int F_RC   = ps_to_cycles(FAST_RC_PS, TCK_PS);
  localparam int S_RCD  = ps_to_cycles(SLOW_RCD_PS, TCK_PS);
  localparam int S_RP   = ps_to_cycles(SLOW_RP_PS, TCK_PS);
  localparam int S_RC   = ps_to_cycles(SLOW_RC_PS, TCK_PS);
  localparam int MAX_C  = max2(max2(max2(F_RCD, F_RP), max2(F_RC, S_RCD)), max2(S_RP, S_RC));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  logic [CNT_W-1:0]     rcd_rl, rp_rl, rc_rl;
  logic [NUM_BANKS-1:0] open_vec, col_ok_vec, pre_ok_vec, cyc_ok_vec;
  logic [NUM_BANKS-1:0] open_go, close_go;
  verdict_e             verdict;

  bank_interval_sel #(
    .CNT_W(CNT_W), .F_RCD(F_RCD), .F_RP(F_RP), .F_RC(F_RC),
    .S_RCD(S_RCD), .S_RP(S_RP), .S_RC(S_RC)
  ) u_sel (
    .bin_sel (bin_sel),
    .rcd_rl  (rcd_rl),
    .rp_rl   (rp_rl),
    .rc_rl   (rc_rl)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .open_go  (open_go[b]),
      .close_go (close_go[b]),
      .rcd_rl   (rcd_rl),
      .rp_rl    (rp_rl),
      .rc_rl    (rc_rl),
      .row_open (open_vec[b]),
      .col_ok   (col_ok_vec[b]),
      .pre_ok   (pre_ok_vec[b]),
      .cyc_ok   (cyc_ok_vec[b])
    );
  end

  bank_cmd_judge #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_judge (
    .req_valid  (req_valid),
    .req_cmd    (req_cmd),
    .req_bank   (req_bank),
    .open_vec   (open_vec),
    .col_ok_vec (col_ok_vec),
    .pre_ok_vec (pre_ok_vec),
    .cyc_ok_vec (cyc_ok_vec),
    .verdict    (verdict),
    .open_go    (open_go),
    .close_go   (close_go)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_grant <= 1'b0;
      rsp_stall <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_grant <= (verdict == VERD_GRANT);
      rsp_stall <= (verdict == VERD_STALL);
      rsp_err   <= (verdict == VERD_ERR);
    end
  end

  assign bank_open = open_vec;

endmodule

// File: rtl/bank_timing_guard_chk.sv
module bank_timing_guard_chk
  import bank_timing_pkg::*;
#(
  parameter int NUM_BANKS   = 8,
  parameter int TCK_PS      = 2500,
  parameter int FAST_RCD_PS = 12500,
  parameter int FAST_RP_PS  = 12500,
  parameter int FAST_RC_PS  = 57500,
  parameter int SLOW_RCD_PS = 15000,
  parameter int SLOW_RP_PS  = 15000,
  parameter int SLOW_RC_PS  = 60000
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bin_sel,
  input logic                 req_valid,
  input logic [2:0]           req_cmd,
  input logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input logic                 rsp_grant,
  input logic                 rsp_stall,
  input logic                 rsp_err,
  input logic [NUM_BANKS-1:0] bank_open
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  int rcd_need, rp_need, rc_need;
  assign rcd_need = bin_sel ? ps_to_cycles(SLOW_RCD_PS, TCK_PS) : ps_to_cycles(FAST_RCD_PS, TCK_PS);
  assign rp_need  = bin_sel ? ps_to_cycles(SLOW_RP_PS, TCK_PS)  : ps_to_cycles(FAST_RP_PS, TCK_PS);
  assign rc_need  = bin_sel ? ps_to_cycles(SLOW_RC_PS, TCK_PS)  : ps_to_cycles(FAST_RC_PS, TCK_PS);

  logic                 prev_valid;
  logic [2:0]           prev_cmd;
  logic [BANK_W-1:0]    prev_bank;
  logic [NUM_BANKS-1:0] prev_open;
  logic [7:0]           act_age [NUM_BANKS];
  logic [7:0]           pre_age [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_valid <= 1'b0;
      prev_cmd   <= '0;
      prev_bank  <= '0;
      prev_open  <= '0;
    end else begin
      prev_valid <= req_valid;
      prev_cmd   <= req_cmd;
      prev_bank  <= req_bank;
      prev_open  <= bank_open;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_age
    always_ff @(posedge clk) begin
      if (rst) begin
        act_age[b] <= 8'hFF;
        pre_age[b] <= 8'hFF;
      end else begin
        if (rsp_grant && prev_valid && prev_cmd == CMD_ACT && prev_bank == BANK_W'(b))
          act_age[b] <= 8'd1;
        else if (act_age[b] != 8'hFF)
          act_age[b] <= act_age[b] + 8'd1;
        if (rsp_grant && prev_valid && prev_cmd == CMD_PRE && prev_bank == BANK_W'(b) && prev_open[b])
          pre_age[b] <= 8'd1;
        else if (pre_age[b] != 8'hFF)
          pre_age[b] <= pre_age[b] + 8'd1;
      end
    end
  end

  logic is_col, is_act, is_ref, is_cmd;
  assign is_col = req_valid && (req_cmd == CMD_RD || req_cmd == CMD_WR);
  assign is_act = req_valid && (req_cmd == CMD_ACT);
  assign is_ref = req_valid && (req_cmd == CMD_REF);
  assign is_cmd = req_valid && (req_cmd >= 3'd1) && (req_cmd <= 3'd5);

  assert_single_resp_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_grant, rsp_stall, rsp_err}));

  assert_quiet_no_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    !is_cmd |=> !(rsp_grant || rsp_stall || rsp_err));

  assert_act_open_err_R3: assert property (@(posedge clk) disable iff (rst)
    (is_act && bank_open[req_bank]) |=> rsp_err);

  assert_col_closed_err_R4: assert property (@(posedge clk) disable iff (rst)
    (is_col && !bank_open[req_bank]) |=> rsp_err);

  assert_col_window_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && prev_valid && (prev_cmd == CMD_RD || prev_cmd == CMD_WR))
      |-> (int'(act_age[prev_bank]) >= rcd_need));

  assert_pre_window_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && prev_valid && prev_cmd == CMD_ACT) |-> (int'(pre_age[prev_bank]) >= rp_need));

  assert_rc_window_R6: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && prev_valid && prev_cmd == CMD_ACT) |-> (int'(act_age[prev_bank]) >= rc_need));

  assert_pre_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (rsp_grant && prev_valid && prev_cmd == CMD_PRE) |-> !bank_open[prev_bank]);

  assert_ref_open_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (is_ref && (bank_open != '0)) |=> rsp_stall);

  assert_reject_keeps_state_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_stall || rsp_err) |-> $stable(bank_open));

endmodule

bind bank_timing_guard bank_timing_guard_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bin_sel   (bin_sel),
  .req_valid (req_valid),
  .req_cmd   (req_cmd),
  .req_bank  (req_bank),
  .rsp_grant (rsp_grant),
  .rsp_stall (rsp_stall),
  .rsp_err   (rsp_err),
  .bank_open (bank_open)
);

// File: tb/sim_bank_timing_guard.sv
module sim_bank_timing_guard;

  localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3,
                         C_PRE = 3'd4, C_REF = 3'd5;
  localparam int K_NONE = 0, K_GRANT = 1, K_STALL = 2, K_ERR = 3;

  logic       clk = 1'b0;
  logic       rst;
  logic       bin_sel;
  logic       req_valid;
  logic [2:0] req_cmd;
  logic [2:0] req_bank;
  logic       rsp_grant, rsp_stall, rsp_err;
  logic [7:0] bank_open;

  always #5 clk = ~clk;

  bank_timing_guard u0 (
    .clk(clk), .rst(rst), .bin_sel(bin_sel), .req_valid(req_valid),
    .req_cmd(req_cmd), .req_bank(req_bank), .rsp_grant(rsp_grant),
    .rsp_stall(rsp_stall), .rsp_err(rsp_err), .bank_open(bank_open)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] tb_open;
  int         q_kind[$];
  logic [7:0] q_open[$];
  string      q_tag[$];

  task automatic check_val(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: presents one request for one cycle and queues the expected result
  task automatic send(input logic [2:0] c, input logic [2:0] b, input int k, input string tag);
    req_valid = 1'b1;
    req_cmd   = c;
    req_bank  = b;
    if (k == K_GRANT && c == C_ACT) tb_open[b] = 1'b1;
    if (k == K_GRANT && c == C_PRE) tb_open[b] = 1'b0;
    q_kind.push_back(k);
    q_open.push_back(tb_open);
    q_tag.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0;
    req_cmd   = C_NOP;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected item per presented request
  initial begin
    forever begin
      logic had;
      @(posedge clk);
      had = req_valid && !rst;
      #2;
      if (had && q_kind.size() > 0) begin
        int         k;
        logic [7:0] ov;
        string      t;
        logic [2:0] exp_r;
        k  = q_kind.pop_front();
        ov = q_open.pop_front();
        t  = q_tag.pop_front();
        exp_r = (k == K_GRANT) ? 3'b100 : (k == K_STALL) ? 3'b010 :
                (k == K_ERR)   ? 3'b001 : 3'b000;
        check_val({5'd0, rsp_grant, rsp_stall, rsp_err}, {5'd0, exp_r}, {t, " response"});
        check_val(bank_open, ov, {t, " bank_open"});
      end
    end
  end

  task automatic do_reset(input logic sel);
    @(negedge clk);
    rst       = 1'b1;
    bin_sel   = sel;
    req_valid = 1'b0;
    tb_open   = '0;
    idle(3);
    rst = 1'b0;
    check_val({5'd0, rsp_grant, rsp_stall, rsp_err}, 8'd0, "R1 reset response");
    check_val(bank_open, 8'd0, "R1 reset banks");
  endtask

  logic done = 1'b0;

  initial begin
    req_cmd  = C_NOP;
    req_bank = '0;
    do_reset(1'b0);

    // fast grade
    send(C_RD, 3'd2, K_ERR, "R4 R11 read closed");
    send(C_WR, 3'd2, K_ERR, "R4 R11 write closed");
    send(C_NOP, 3'd0, K_NONE, "R2 nop");
    send(3'd6, 3'd1, K_NONE, "R2 code6");
    send(3'd7, 3'd3, K_NONE, "R2 code7");
    send(C_PRE, 3'd4, K_GRANT, "R7 pre closed");

    // precharge interval, bank 1
    send(C_ACT, 3'd1, K_GRANT, "R3 act");
    idle(30);
    send(C_PRE, 3'd1, K_GRANT, "R7 pre open");
    send(C_REF, 3'd0, K_STALL, "R8 ref rp running");
    for (int i = 0; i < 3; i++) send(C_ACT, 3'd1, K_STALL, "R5 act rp stall");
    send(C_ACT, 3'd1, K_GRANT, "R5 act rp boundary");
    send(C_ACT, 3'd1, K_ERR, "R3 R11 act open");

    // precharge on a closed bank restarts nothing
    send(C_PRE, 3'd4, K_GRANT, "R7 pre closed again");
    send(C_ACT, 3'd4, K_GRANT, "R7 no rp restart");
    send(C_PRE, 3'd1, K_GRANT, "R7 close b1");
    send(C_PRE, 3'd4, K_GRANT, "R7 close b4");
    idle(30);
    send(C_REF, 3'd0, K_GRANT, "R8 ref quiet");

    // row-to-column, row cycle, independence
    send(C_ACT, 3'd0, K_GRANT, "R3 act b0");
    send(C_ACT, 3'd3, K_GRANT, "R9 act b3 alongside");
    for (int i = 0; i < 3; i++) send(C_RD, 3'd0, K_STALL, "R4 read rcd stall");
    send(C_RD, 3'd0, K_GRANT, "R4 R10 read rcd boundary");
    send(C_WR, 3'd0, K_GRANT, "R4 write");
    send(C_REF, 3'd0, K_STALL, "R8 R11 ref banks open");
    send(C_PRE, 3'd0, K_GRANT, "R7 pre b0");
    for (int i = 0; i < 14; i++) send(C_ACT, 3'd0, K_STALL, "R6 act rc stall");
    send(C_ACT, 3'd0, K_GRANT, "R6 R10 act rc boundary");
    send(C_RD, 3'd3, K_GRANT, "R9 read b3");
    idle(3);

    // slow grade, reset with banks open
    do_reset(1'b1);
    send(C_ACT, 3'd5, K_GRANT, "R10 slow act");
    for (int i = 0; i < 5; i++) send(C_RD, 3'd5, K_STALL, "R10 slow rcd stall");
    send(C_RD, 3'd5, K_GRANT, "R10 slow rcd boundary");
    send(C_PRE, 3'd5, K_GRANT, "R10 slow pre");
    for (int i = 0; i < 16; i++) send(C_ACT, 3'd5, K_STALL, "R10 slow rc stall");
    send(C_ACT, 3'd5, K_GRANT, "R10 slow rc boundary");
    send(C_ACT, 3'd6, K_GRANT, "R9 slow act b6");
    idle(30);
    send(C_PRE, 3'd6, K_GRANT, "R10 slow pre b6");
    for (int i = 0; i < 5; i++) send(C_ACT, 3'd6, K_STALL, "R10 slow rp stall");
    send(C_ACT, 3'd6, K_GRANT, "R10 slow rp boundary");
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule